// File: doc/BRIEF.md
# No-Load Creep Suppression Gate

This block sits between the measurement datapath and the energy accumulators and pulse-frequency converter of a metering chip. It takes one sample per valid strobe from one of two sources: the apparent-power magnitude, or the current-RMS magnitude when ampere-hour (tamper) mode is selected. It compares the chosen value against a small fraction of full scale. Any sample below that level is replaced by zero, so no energy creeps into the accumulators while the line is unloaded. The valid strobe always passes through, so downstream timing stays the same whether or not a sample is gated.

A two-bit threshold code picks the level. Code zero turns detection off. The three non-zero codes give levels of roughly 0.030 %, 0.015 % and 0.0075 % of full scale, with each code halving the level of the one before it. Every gated sample sets a sticky no-load flag. The flag drives an interrupt request whenever the interrupt is enabled, and it stays set until a clear pulse removes it. A new no-load sample that arrives in the same cycle as the clear keeps the flag set.

Top module: `nl_creep_gate`

## Requirements
- R1: After reset, gated_smp is 0, gated_vld is 0, nl_flag is 0 and irq is 0.
- R2: With nl_mode = 2'b00, every selected sample, including zero, reaches gated_smp unchanged and nl_flag is never set.
- R3: With nl_mode = 2'b01, the threshold is 2517 (about 0.0003 of full scale 2^23). A selected value below 2517 gives gated_smp = 0, and 2517 or more passes unchanged.
- R4: With nl_mode = 2'b10, the threshold is 1258. The comparison is a strict less-than, as in R3.
- R5: With nl_mode = 2'b11, the threshold is 629. The comparison is a strict less-than, as in R3.
- R6: gated_vld is smp_vld delayed by exactly one clock, whether or not the sample is gated. gated_smp holds the result of the sample strobed in the previous cycle.
- R7: ah_sel = 0 selects va_smp and ah_sel = 1 selects irms_smp. The threshold applies to the selected source only.
- R8: A valid sample that is gated sets nl_flag on the next clock. nl_flag then stays at 1 until a stat_clr pulse clears it.
- R9: When a gating sample and stat_clr arrive in the same cycle, nl_flag is 1 afterwards (the set wins).
- R10: irq is 1 exactly when nl_flag is 1 and irq_en is 1. The change in irq_en takes effect in the same cycle.
- R11: In a cycle with smp_vld low, gated_smp keeps its previous value and nl_flag is not set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| va_smp | input | 24 | Apparent-power magnitude, unsigned |
| irms_smp | input | 24 | Current-RMS magnitude, unsigned |
| smp_vld | input | 1 | Sample strobe for both inputs |
| nl_mode | input | 2 | Threshold code: 00 = off, 01 / 10 / 11 = halving levels |
| ah_sel | input | 1 | 1 selects the current-RMS source (ampere-hour mode) |
| irq_en | input | 1 | Interrupt enable for the no-load flag |
| stat_clr | input | 1 | Clear pulse for the no-load flag |
| gated_smp | output | 24 | Sample to the accumulators, forced to 0 when no-load |
| gated_vld | output | 1 | Strobe for gated_smp |
| nl_flag | output | 1 | Sticky no-load status |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the cycle-level rules on every clock. They check that the strobe passes through with one cycle of latency, that a below-threshold sample always comes out as zero, that the output holds between strobes, that the flag stays set and that a set beats a clear, and that the interrupt stays low while it is disabled. Only the bench scenarios can show that the threshold values are correct at each code boundary, including the values just below and at each level. The scenarios also show that the source select really swaps between the two inputs, and that mode zero lets a zero sample through without raising the flag.

// File: rtl/nl_pkg.sv
package nl_pkg;
    localparam int unsigned SMP_W   = 24;
    localparam int unsigned FS_LOG2 = 23;
    localparam int unsigned MODE_W  = 2;

    typedef logic [SMP_W-1:0] smp_t;

    typedef struct packed {
        smp_t data;
        logic vld;
    } out_st_t;

    // Threshold for a non-zero code k: 3 * 2^FS_LOG2 / 10000, halved (k-1) times,
    // rounded to nearest integer.
    function automatic longint unsigned nl_thresh(input int unsigned fs_log2,
                                                  input int unsigned code);
        longint unsigned num;
        num = (longint'(3) << fs_log2) >> (code - 1);
        return (num + 64'd5000) / 64'd10000;
    endfunction
endpackage

// File: rtl/nl_src_mux.sv
module nl_src_mux
    import nl_pkg::*;
#(
    parameter int unsigned W = SMP_W
) (
    input  logic [W-1:0] va_i,
    input  logic [W-1:0] irms_i,
    input  logic         ah_sel_i,
    output logic [W-1:0] sel_o
);
    always_comb begin
        sel_o = ah_sel_i ? irms_i : va_i;
    end
endmodule

// File: rtl/nl_thresh_cmp.sv
module nl_thresh_cmp
    import nl_pkg::*;
#(
    parameter int unsigned W      = SMP_W,
    parameter int unsigned FSL    = FS_LOG2,
    parameter int unsigned MW     = MODE_W
) (
    input  logic [W-1:0]  val_i,
    input  logic [MW-1:0] mode_i,
    output logic          below_o
);
    localparam int unsigned N_CODE = 1 << MW;

    logic [W-1:0]     thr   [N_CODE];
    logic [N_CODE-1:0] hit;

    // Code 0 disables detection; others carry a halving threshold.
    for (genvar k = 0; k < N_CODE; k++) begin : g_lvl
        if (k == 0) begin : g_off
            assign thr[k] = '0;
            assign hit[k] = 1'b0;
        end else begin : g_on
            localparam longint unsigned TV = nl_thresh(FSL, k);
            assign thr[k] = W'(TV);
            assign hit[k] = (val_i < thr[k]);
        end
    end

    always_comb begin
        below_o = hit[mode_i];
    end
endmodule

// File: rtl/nl_status.sv
module nl_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic irq_en_i,
    output logic flag_o,
    output logic irq_o
);
    typedef struct packed {
        logic flag;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i)
            st_d.flag = 1'b1;
        else if (clr_i)
            st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
    assign irq_o  = st_q.flag & irq_en_i;

    // R9: a set event wins over a same-cycle clear
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && clr_i) |=> flag_o);
    // R8: flag is sticky without a clear
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
    // R10: no interrupt while disabled
    a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en_i |-> !irq_o);
endmodule

// File: rtl/nl_creep_gate.sv
module nl_creep_gate
    import nl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SMP_W-1:0]  va_smp,
    input  logic [SMP_W-1:0]  irms_smp,
    input  logic              smp_vld,
    input  logic [MODE_W-1:0] nl_mode,
    input  logic              ah_sel,
    input  logic              irq_en,
    input  logic              stat_clr,
    output logic [SMP_W-1:0]  gated_smp,
    output logic              gated_vld,
    output logic              nl_flag,
    output logic              irq
);
    smp_t    sel_val;
    logic    below;
    logic    nl_set;
    out_st_t out_d, out_q;

    nl_src_mux #(.W(SMP_W)) i_mux (
        .va_i     (va_smp),
        .irms_i   (irms_smp),
        .ah_sel_i (ah_sel),
        .sel_o    (sel_val)
    );

    nl_thresh_cmp #(.W(SMP_W), .FSL(FS_LOG2), .MW(MODE_W)) i_cmp (
        .val_i   (sel_val),
        .mode_i  (nl_mode),
        .below_o (below)
    );

    assign nl_set = smp_vld & below;

    nl_status i_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (nl_set),
        .clr_i    (stat_clr),
        .irq_en_i (irq_en),
        .flag_o   (nl_flag),
        .irq_o    (irq)
    );

    always_comb begin
        out_d     = out_q;
        out_d.vld = smp_vld;
        if (smp_vld)
            out_d.data = below ? '0 : sel_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign gated_smp = out_q.data;
    assign gated_vld = out_q.vld;

    // R6: strobe passes with one cycle of latency
    a_r6_vld_delay: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |=> gated_vld);
    a_r6_no_vld: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> !gated_vld);
    // R3: a below-threshold sample comes out as zero
    a_r3_gate_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && below) |=> (gated_smp == '0));
    // R2: with detection off, the selected source passes unchanged
    a_r2_mode0_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && nl_mode == '0) |=>
        (gated_smp == $past(ah_sel ? irms_smp : va_smp)));
    // R11: output holds between strobes
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> $stable(gated_smp));
endmodule

// File: tb/test_nl_creep_gate.sv
module test_nl_creep_gate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] va_smp = '0, irms_smp = '0;
    logic        smp_vld = 1'b0;
    logic [1:0]  nl_mode = '0;
    logic        ah_sel = 1'b0, irq_en = 1'b0, stat_clr = 1'b0;
    logic [23:0] gated_smp;
    logic        gated_vld, nl_flag, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    nl_creep_gate i_nl_creep_gate (
        .clk(clk), .rst_n(rst_n), .va_smp(va_smp), .irms_smp(irms_smp),
        .smp_vld(smp_vld), .nl_mode(nl_mode), .ah_sel(ah_sel),
        .irq_en(irq_en), .stat_clr(stat_clr), .gated_smp(gated_smp),
        .gated_vld(gated_vld), .nl_flag(nl_flag), .irq(irq)
    );

    // {mode, ah_sel, va, irms, expected out, expected flag}
    typedef struct packed {
        logic [1:0]  mode;
        logic        ah;
        logic [23:0] va;
        logic [23:0] irms;
        logic [23:0] exp_out;
        logic        exp_flag;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 1'b0, 24'd5,      24'd0,    24'd5,      1'b0}, // R2
        '{2'd0, 1'b1, 24'd0,      24'd0,    24'd0,      1'b0}, // R2 zero
        '{2'd1, 1'b0, 24'd2516,   24'd0,    24'd0,      1'b1}, // R3
        '{2'd1, 1'b0, 24'd2517,   24'd0,    24'd2517,   1'b0}, // R3
        '{2'd2, 1'b0, 24'd1257,   24'd0,    24'd0,      1'b1}, // R4
        '{2'd2, 1'b0, 24'd1258,   24'd0,    24'd1258,   1'b0}, // R4
        '{2'd3, 1'b0, 24'd628,    24'd0,    24'd0,      1'b1}, // R5
        '{2'd3, 1'b0, 24'd629,    24'd0,    24'd629,    1'b0}, // R5
        '{2'd1, 1'b1, 24'd100000, 24'd2000, 24'd0,      1'b1}, // R7
        '{2'd1, 1'b1, 24'd10,     24'd3000, 24'd3000,   1'b0}, // R7
        '{2'd1, 1'b0, 24'd3000,   24'd10,   24'd3000,   1'b0}, // R7
        '{2'd3, 1'b0, 24'hFFFFFF, 24'd0,    24'hFFFFFF, 1'b0}  // R5 top
    };

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // drive at negedge, let one posedge pass, sample 1 ns later
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1 smp", 32'(gated_smp), 0);
        check("R1 vld", 32'(gated_vld), 0);
        check("R1 flag", 32'(nl_flag), 0);
        check("R1 irq", 32'(irq), 0);
        @(negedge clk);
        rst_n = 1'b1;
        irq_en = 1'b1;

        // Table walk: clear each cycle, so the flag equals this sample's set (R9)
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            nl_mode  = VEC[i].mode;
            ah_sel   = VEC[i].ah;
            va_smp   = VEC[i].va;
            irms_smp = VEC[i].irms;
            smp_vld  = 1'b1;
            stat_clr = 1'b1;
            step();
            check("R3/R4/R5/R7 out", 32'(gated_smp), 32'(VEC[i].exp_out));
            check("R6 vld", 32'(gated_vld), 1);
            check("R9/R8 flag", 32'(nl_flag), 32'(VEC[i].exp_flag));
            check("R10 irq", 32'(irq), 32'(VEC[i].exp_flag));
        end

        // R11: idle cycle with a gating value on the inputs
        @(negedge clk);
        smp_vld  = 1'b0;
        stat_clr = 1'b0;
        nl_mode  = 2'd1;
        ah_sel   = 1'b0;
        va_smp   = 24'd3;
        step();
        check("R11 hold", 32'(gated_smp), 32'hFFFFFF);
        check("R6 idle vld", 32'(gated_vld), 0);
        check("R11 no set", 32'(nl_flag), 0);

        // R8: set then sticky across idle cycles, then clear
        @(negedge clk);
        smp_vld = 1'b1;
        step();
        check("R8 set", 32'(nl_flag), 1);
        @(negedge clk);
        smp_vld = 1'b0;
        repeat (3) step();
        check("R8 sticky", 32'(nl_flag), 1);

        // R10: enable masks the request immediately
        @(negedge clk);
        irq_en = 1'b0;
        #1;
        check("R10 masked", 32'(irq), 0);
        @(negedge clk);
        irq_en = 1'b1;
        #1;
        check("R10 unmasked", 32'(irq), 1);

        @(negedge clk);
        stat_clr = 1'b1;
        step();
        check("R8 cleared", 32'(nl_flag), 0);
        check("R10 cleared", 32'(irq), 0);

        // R2: mode 0 never sets the flag, even for a tiny value
        @(negedge clk);
        stat_clr = 1'b0;
        nl_mode  = 2'd0;
        va_smp   = 24'd1;
        smp_vld  = 1'b1;
        step();
        check("R2 pass", 32'(gated_smp), 1);
        check("R2 no flag", 32'(nl_flag), 0);

        @(negedge clk);
        smp_vld = 1'b0;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule